// File: doc/BRIEF.md
# Ten-bit ROM window mapper

This block answers reads into a window of ten-bit words placed inside a host address space of 64K words, split into sixteen 4K-word blocks. The window is held in two byte-wide memories outside the block. A low store supplies bits 7..0 of each word, and it may be built from one device or from two devices placed back to back. A packed high store supplies bits 9..8, with four words sharing each byte.

For each host word address the block works out whether the address lies in the window. On a hit it drives the byte addresses and chip selects of both stores. One clock later the stores return their bytes, and the block picks the right two-bit group out of the high byte, adds the low byte below it, and raises the hit flag.

Two four-bit inputs set up the window. One gives the starting block. The other gives the window size and how the low store is split between its devices.

Top module: `rom_window_map`

## Requirements
- R1: A start block below 8 never produces a hit. With such a start block, `hit_o` stays low and every chip select stays low for every address.
- R2: With a start block s of 8 or more, an address a hits only when a >= s*4096. Addresses below the window base are misses.
- R3: `win_cfg_i[1:0]` sets the window size in words: 0 gives 4096, 1 gives 8192, 2 gives 16384 and 3 gives 32768. An address hits only when its offset a - s*4096 is below that size. The window is also clipped at the top of the 64K space.
- R4: `win_cfg_i[3:2]` sets how the low store is split. Code 0 means one device, so `lo_cs_o`=01 and `lo_addr_o`=offset. Codes 1, 2 and 3 mean the first device holds 4096, 8192 or 16384 bytes (cap). If the offset is below cap, `lo_cs_o`=01 and `lo_addr_o`=offset. Otherwise `lo_cs_o`=10 and `lo_addr_o`=offset-cap. Both selects are driven in the same cycle as the address.
- R5: On a hit, `hi_cs_o`=1 and `hi_addr_o`=offset>>2, in the same cycle as the address.
- R6: Bits 9..8 of the returned word come from bits [2g+1:2g] of the high byte, where g=offset[1:0].
- R7: The data and hit flag for an address appear one clock after it. `data_o`={group, low byte}, where the low byte comes from the device that was selected.
- R8: On a miss, all chip selects are low in the address cycle. In the next cycle `data_o`=0 and `hit_o`=0.
- R9: While `rst_ni` is low, `hit_o`=0 and `data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Host word address |
| start_blk_i | input | 4 | First 4K block of the window |
| win_cfg_i | input | 4 | [1:0] window size code, [3:2] low-store split code |
| lo_addr_o | output | 15 | Byte address to the low-store devices |
| lo_cs_o | output | 2 | One-hot select of low device 0 or 1 |
| lo0_data_i | input | 8 | Read byte from low device 0 (one-cycle latency) |
| lo1_data_i | input | 8 | Read byte from low device 1 (one-cycle latency) |
| hi_addr_o | output | 13 | Byte address to the packed high store |
| hi_cs_o | output | 1 | High-store select |
| hi_data_i | input | 8 | Read byte from the high store (one-cycle latency) |
| data_o | output | 10 | Assembled word |
| hit_o | output | 1 | Word valid and output enabled |

## Verification
The bench sweeps every start block, size code and split code, and aims at the addresses one below and one above the window base, the window end, the end of the first low device and the top of the address space.

- A base or limit comparison that is off by one would answer a neighbouring word.
- A wrong device boundary would read the wrong device, or would leave the second device's addresses starting above zero.
- Walking offsets through all four phases mod 4 exposes a reversed or shifted group select in the high bits.
- Start blocks below 8 catch a decoder that answers the reserved region.

// File: rtl/rom_win_pkg.sv
package rom_win_pkg;
  typedef enum logic [1:0] {WIN_4K, WIN_8K, WIN_16K, WIN_32K} win_size_e;
  typedef enum logic [1:0] {LO_SINGLE, LO_SPLIT_4K, LO_SPLIT_8K, LO_SPLIT_16K} lo_split_e;
endpackage

// File: rtl/rom_win_decode.sv
module rom_win_decode
  import rom_win_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLK_LOG2  = 12,
  parameter int FIRST_BLK = 8,
  localparam int BLK_SEL_W = ADDR_W - BLK_LOG2
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BLK_SEL_W-1:0] start_blk_i,
  input  win_size_e            size_i,
  output logic                 hit_o,
  output logic [ADDR_W-1:0]    off_o
);
  logic [ADDR_W:0] base, diff, lim;

  always_comb begin
    base  = {1'b0, start_blk_i, {BLK_LOG2{1'b0}}};
    diff  = {1'b0, addr_i} - base;
    off_o = diff[ADDR_W-1:0];
    lim   = (ADDR_W+1)'(1) << (BLK_LOG2 + int'(size_i));
    // diff[ADDR_W] set means the address lies below the base
    hit_o = (int'(start_blk_i) >= FIRST_BLK) && !diff[ADDR_W] && ({1'b0, off_o} < lim);
  end
endmodule

// File: rtl/rom_win_addr_gen.sv
module rom_win_addr_gen
  import rom_win_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BLK_LOG2 = 12,
  parameter int LO_AW    = 15,
  parameter int N_DEV    = 2,
  parameter int GRP_W    = 2,
  localparam int HI_AW   = LO_AW - GRP_W
) (
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] off_i,
  input  lo_split_e         split_i,
  output logic [LO_AW-1:0]  lo_addr_o,
  output logic [N_DEV-1:0]  lo_cs_o,
  output logic              dev_o,
  output logic [HI_AW-1:0]  hi_addr_o,
  output logic              hi_cs_o,
  output logic [GRP_W-1:0]  grp_o
);
  logic [LO_AW-1:0] cap;

  always_comb begin
    cap   = '0;
    dev_o = 1'b0;
    if (split_i != LO_SINGLE) begin
      cap   = LO_AW'(1) << (BLK_LOG2 + int'(split_i) - 1);
      dev_o = off_i >= ADDR_W'(cap);
    end
    lo_addr_o = dev_o ? off_i[LO_AW-1:0] - cap : off_i[LO_AW-1:0];
    hi_addr_o = off_i[LO_AW-1:GRP_W];
    grp_o     = off_i[GRP_W-1:0];
    hi_cs_o   = hit_i;
  end

  for (genvar d = 0; d < N_DEV; d++) begin : g_cs
    assign lo_cs_o[d] = hit_i && (int'(dev_o) == d);
  end

  always_comb begin
    // R4
    lo_cs_onehot_chk: assert ($onehot0(lo_cs_o));
    // R3
    if (hit_i) win_range_chk: assert (off_i[ADDR_W-1:LO_AW] == '0);
  end
endmodule

// File: rtl/rom_win_assemble.sv
module rom_win_assemble #(
  parameter int LO_W  = 8,
  parameter int GRP_W = 2,
  localparam int HI_W = LO_W,
  localparam int N_GRP = HI_W / GRP_W,
  localparam int SEL_W = $clog2(N_GRP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             dev_i,
  input  logic [SEL_W-1:0] grp_i,
  input  logic [LO_W-1:0]  lo0_data_i,
  input  logic [LO_W-1:0]  lo1_data_i,
  input  logic [HI_W-1:0]  hi_data_i,
  output logic [LO_W+GRP_W-1:0] data_o,
  output logic             hit_o
);
  logic             hit_q, dev_q;
  logic [SEL_W-1:0] grp_q;
  logic [N_GRP-1:0][GRP_W-1:0] grp_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      dev_q <= 1'b0;
      grp_q <= '0;
    end else begin
      hit_q <= hit_i;
      dev_q <= dev_i;
      grp_q <= grp_i;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_vec[g] = hi_data_i[g*GRP_W +: GRP_W];
  end

  assign hit_o  = hit_q;
  assign data_o = hit_q ? {grp_vec[grp_q], (dev_q ? lo1_data_i : lo0_data_i)} : '0;

  // R7
  hit_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) hit_i |=> hit_o);
endmodule

// File: rtl/rom_window_map.sv
module rom_window_map
  import rom_win_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLK_LOG2  = 12,
  parameter int FIRST_BLK = 8,
  parameter int LO_AW     = 15,
  parameter int LO_W      = 8,
  parameter int GRP_W     = 2,
  localparam int BLK_SEL_W = ADDR_W - BLK_LOG2,
  localparam int HI_AW     = LO_AW - GRP_W,
  localparam int N_DEV     = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [BLK_SEL_W-1:0]  start_blk_i,
  input  logic [3:0]            win_cfg_i,
  output logic [LO_AW-1:0]      lo_addr_o,
  output logic [N_DEV-1:0]      lo_cs_o,
  input  logic [LO_W-1:0]       lo0_data_i,
  input  logic [LO_W-1:0]       lo1_data_i,
  output logic [HI_AW-1:0]      hi_addr_o,
  output logic                  hi_cs_o,
  input  logic [LO_W-1:0]       hi_data_i,
  output logic [LO_W+GRP_W-1:0] data_o,
  output logic                  hit_o
);
  logic              hit;
  logic              dev;
  logic [ADDR_W-1:0] off;
  logic [GRP_W-1:0]  grp;

  rom_win_decode #(
    .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .FIRST_BLK(FIRST_BLK)
  ) u_decode (
    .addr_i     (addr_i),
    .start_blk_i(start_blk_i),
    .size_i     (win_size_e'(win_cfg_i[1:0])),
    .hit_o      (hit),
    .off_o      (off)
  );

  rom_win_addr_gen #(
    .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .LO_AW(LO_AW), .N_DEV(N_DEV), .GRP_W(GRP_W)
  ) u_addr_gen (
    .hit_i    (hit),
    .off_i    (off),
    .split_i  (lo_split_e'(win_cfg_i[3:2])),
    .lo_addr_o(lo_addr_o),
    .lo_cs_o  (lo_cs_o),
    .dev_o    (dev),
    .hi_addr_o(hi_addr_o),
    .hi_cs_o  (hi_cs_o),
    .grp_o    (grp)
  );

  rom_win_assemble #(
    .LO_W(LO_W), .GRP_W(GRP_W)
  ) u_assemble (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .dev_i     (dev),
    .grp_i     (grp),
    .lo0_data_i(lo0_data_i),
    .lo1_data_i(lo1_data_i),
    .hi_data_i (hi_data_i),
    .data_o    (data_o),
    .hit_o     (hit_o)
  );

  always_comb begin
    // R1
    if (|lo_cs_o) low_blk_chk: assert (int'(start_blk_i) >= FIRST_BLK);
    // R5
    hi_lo_sel_chk: assert (hi_cs_o == (|lo_cs_o));
  end

  // R8
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|lo_cs_o) |=> (data_o == '0 && !hit_o));
endmodule

// File: tb/rom_window_map_tb.sv
module rom_window_map_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [3:0]  start_blk_i = '0;
  logic [3:0]  win_cfg_i = '0;
  logic [14:0] lo_addr_o;
  logic [1:0]  lo_cs_o;
  logic [7:0]  lo0_data_i = '0, lo1_data_i = '0, hi_data_i = '0;
  logic [12:0] hi_addr_o;
  logic        hi_cs_o;
  logic [9:0]  data_o;
  logic        hit_o;

  int checks = 0, errors = 0;
  bit pend = 0;
  int p_data, p_hit;
  string p_req;

  always #4 clk_i = ~clk_i;

  rom_window_map u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .start_blk_i(start_blk_i),
    .win_cfg_i(win_cfg_i), .lo_addr_o(lo_addr_o), .lo_cs_o(lo_cs_o),
    .lo0_data_i(lo0_data_i), .lo1_data_i(lo1_data_i), .hi_addr_o(hi_addr_o),
    .hi_cs_o(hi_cs_o), .hi_data_i(hi_data_i), .data_o(data_o), .hit_o(hit_o)
  );

  function automatic int f0(int x); return (x * 7 + 3) & 255; endfunction
  function automatic int f1(int x); return (x * 13 + 90) & 255; endfunction
  function automatic int fh(int x); return (x * 29 + 195) & 255; endfunction

  // synchronous store models, one-cycle latency
  always @(posedge clk_i) begin
    if (lo_cs_o[0]) lo0_data_i <= 8'(f0(int'(lo_addr_o)));
    if (lo_cs_o[1]) lo1_data_i <= 8'(f1(int'(lo_addr_o)));
    if (hi_cs_o)    hi_data_i  <= 8'(fh(int'(hi_addr_o)));
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(int a, int s, int sz, int sp);
    int base, size, off, cap, dev, la, lo, hi, hit;
    string rq;
    @(negedge clk_i);
    if (pend) begin
      chk(p_req, "data_o", int'(data_o), p_data);
      chk("R7", "hit_o", int'(hit_o), p_hit);
    end
    a = a & 16'hFFFF;
    addr_i = 16'(a); start_blk_i = 4'(s); win_cfg_i = {2'(sp), 2'(sz)};
    base = s * 4096; size = 4096 << sz; off = a - base;
    hit = (s >= 8 && a >= base && off < size) ? 1 : 0;
    cap = (sp == 0) ? (1 << 30) : (4096 << (sp - 1));
    dev = (off >= cap) ? 1 : 0;
    la = dev ? off - cap : off;
    lo = dev ? f1(la) : f0(la);
    hi = (fh(off >> 2) >> (2 * (off & 3))) & 3;
    #1;
    if (s < 8) rq = "R1"; else if (a >= base) rq = "R3"; else rq = "R2";
    chk(rq, "hit decision", int'(|lo_cs_o), hit);
    if (hit) begin
      chk("R4", "lo_cs_o", int'(lo_cs_o), dev ? 2 : 1);
      chk("R4", "lo_addr_o", int'(lo_addr_o), la);
      chk("R5", "hi_addr_o", int'(hi_addr_o), off >> 2);
      chk("R5", "hi_cs_o", int'(hi_cs_o), 1);
    end else begin
      chk("R8", "selects on miss", int'({hi_cs_o, lo_cs_o}), 0);
    end
    pend = 1;
    p_hit = hit;
    p_data = hit ? ((hi << 8) | lo) : 0;
    p_req = hit ? "R6" : "R8";
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    addr_i = 16'h9000; start_blk_i = 4'd9; win_cfg_i = 4'h3;
    repeat (3) @(negedge clk_i);
    chk("R9", "hit_o in reset", int'(hit_o), 0);
    chk("R9", "data_o in reset", int'(data_o), 0);
    rst_ni = 1'b1;
    for (int s = 0; s < 16; s++)
      for (int sz = 0; sz < 4; sz++)
        for (int sp = 0; sp < 4; sp++) begin
          int base = s * 4096;
          int size = 4096 << sz;
          int cap = (sp == 0) ? 4096 : (4096 << (sp - 1));
          access(base - 1, s, sz, sp);
          access(base, s, sz, sp);
          access(base + 1, s, sz, sp);
          access(base + size - 1, s, sz, sp);
          access(base + size, s, sz, sp);
          access(base + size + 1, s, sz, sp);
          access(base + cap - 1, s, sz, sp);
          access(base + cap, s, sz, sp);
          access(base + cap + 1, s, sz, sp);
          access(base + cap + 2, s, sz, sp);
          access(65535, s, sz, sp);
          for (int k = 0; k < 48; k++) access(base + (k * 389) % size, s, sz, sp);
          for (int k = 0; k < 24; k++) access(k * 2731 + s * 77, s, sz, sp);
        end
    access(0, 0, 0, 0);
    access(0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule